// File: doc/BRIEF.md
# Default Subordinate with Fault Classification and Logging

This block sits beside the address decoder of an AHB-Lite bus and watches every address phase. It holds a small table of address regions, each with a base, a mask, a secure-only flag and the largest transfer size the region accepts. An active transfer can fail in three ways. It can match no region. It can be a non-secure access to a secure region. Or its size can be larger than the matching region allows. In each of these cases the block takes over the data phase and answers with the two-cycle ERROR response. Every other transfer is left to the real subordinates, and this block keeps answering OKAY with no wait state.

Each fault is classified by cause. The address and attributes sampled in the failing transfer's own address phase are kept in a fault record, which software reads through plain status pins. This matters because the address on the bus while the ERROR is showing already belongs to the next transfer. The record stays put until a clear pulse arrives. A second fault that comes while the record is full only raises an overflow flag.

Top module: `bus_fault_responder`

## Requirements
- R1: An active transfer (htrans NONSEQ=2'b10 or SEQ=2'b11, accepted when hready is high) whose address matches no region gets ERROR and is logged with class 2'b01.
- R2: Every ERROR takes two cycles: hresp=1 with hreadyout=0, then hresp=1 with hreadyout=1. hresp=0 means OKAY.
- R3: A region matches when (haddr & mask) == base. A transfer with hnonsec=1 that hits a secure region gets ERROR with class 2'b10. A transfer with hnonsec=0 that hits the same region completes OKAY.
- R4: A transfer whose hsize is larger than the region's maximum gets ERROR with class 2'b11. When the security rule and the size rule both fail, the class is 2'b10.
- R5: When regions overlap, the lowest-numbered matching region decides the rules.
- R6: The logged address, hsize, hwrite and hnonsec are the values from the failing transfer's address phase. The values on the bus while the ERROR is showing are not used.
- R7: IDLE (2'b00) and BUSY (2'b01) transfers get OKAY with hreadyout=1 and are not logged, even when they go to unmapped addresses. Legal accesses to mapped regions are not logged either.
- R8: When a fault arrives while flt_valid=1, flt_overflow is set and the first record is kept unchanged.
- R9: A one-cycle flt_clear pulse empties the record: flt_valid=0, flt_class=2'b00 and flt_overflow=0. If a fault is accepted in the same cycle as the clear, that fault is logged and flt_overflow stays 0.
- R10: After reset, hreadyout=1, hresp=0, flt_valid=0, flt_class=2'b00 and flt_overflow=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| htrans | input | 2 | Transfer type of the current address phase |
| haddr | input | AW | Address of the current address phase |
| hsize | input | 3 | Transfer size as a power of two in bytes |
| hwrite | input | 1 | 1 for a write |
| hnonsec | input | 1 | 1 for a non-secure access |
| hready | input | 1 | Bus ready; the address phase is taken when this is high |
| hreadyout | output | 1 | Ready from this block for its data phase |
| hresp | output | 1 | 0 for OKAY, 1 for ERROR |
| flt_clear | input | 1 | Pulse that empties the fault record |
| flt_valid | output | 1 | The fault record holds a fault |
| flt_class | output | 2 | Fault cause: 00 none, 01 unmapped, 10 security, 11 size |
| flt_addr | output | AW | Address of the logged fault |
| flt_size | output | 3 | hsize of the logged fault |
| flt_write | output | 1 | hwrite of the logged fault |
| flt_nonsec | output | 1 | hnonsec of the logged fault |
| flt_overflow | output | 1 | A further fault arrived while the record was full |

## Verification
A wrong decode or a wrong priority shows up as a bad response in the cycle right after the address phase: an OKAY where an ERROR was due, or an ERROR where an OKAY was due. A broken response sequencer shows up one or two cycles later, as a single-cycle ERROR, a missing wait state, or a stuck hreadyout. The pending transfer behind it then stalls, and the bench notices. A fault record taken from the wrong pipeline stage carries the address of the next transfer, which the bench sees as soon as the response finishes. Bad overflow or clear handling shows up on the status pins in the cycle after the pulse or the second fault.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  typedef enum logic [1:0] {
    FC_NONE     = 2'b00,
    FC_UNMAPPED = 2'b01,
    FC_SECURE   = 2'b10,
    FC_SIZE     = 2'b11
  } fault_cls_e;

  typedef enum logic [1:0] {
    RS_IDLE     = 2'b00,
    RS_ERR_WAIT = 2'b01,
    RS_ERR_DONE = 2'b10
  } rsp_st_e;

  typedef struct packed {
    logic       nonsec;
    logic       write;
    logic [2:0] size;
  } xfer_attr_t;

endpackage

// File: rtl/bfr_region_match.sv
module bfr_region_match
  import bfr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] RGN_BASE   = '0,
  parameter logic [NREG-1:0][AW-1:0] RGN_MASK   = '0,
  parameter logic [NREG-1:0]         RGN_SECURE = '0,
  parameter logic [NREG-1:0][2:0]    RGN_MAXSZ  = '0
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  input  logic          nonsec,
  output fault_cls_e    cls
);

  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0] match;
  logic            hit;
  logic [IDXW-1:0] hit_idx;

  // One comparator per region.
  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    assign match[g] = ((addr & RGN_MASK[g]) == RGN_BASE[g]);
  end

  // Walk from the top index down so the lowest matching index is left in hit_idx.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDXW'(i);
      end
    end
  end

  // The security rule is checked before the size rule.
  always_comb begin
    if (!hit)                                  cls = FC_UNMAPPED;
    else if (RGN_SECURE[hit_idx] && nonsec)    cls = FC_SECURE;
    else if (size > RGN_MAXSZ[hit_idx])        cls = FC_SIZE;
    else                                       cls = FC_NONE;
  end

endmodule

// File: rtl/bfr_resp_fsm.sv
module bfr_resp_fsm
  import bfr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_err,
  output logic hreadyout,
  output logic hresp
);

  rsp_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RS_IDLE:     if (take_err) st_d = RS_ERR_WAIT;
      RS_ERR_WAIT: st_d = RS_ERR_DONE;
      RS_ERR_DONE: st_d = take_err ? RS_ERR_WAIT : RS_IDLE;
      default:     st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  assign hresp     = (st_q == RS_ERR_WAIT) || (st_q == RS_ERR_DONE);
  assign hreadyout = (st_q != RS_ERR_WAIT);

  // R2: the wait cycle of an ERROR is always followed by the completing cycle.
  assert_err_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R2: a completing ERROR cycle always has a wait cycle right before it.
  assert_err_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && hreadyout) |-> $past(hresp && !hreadyout));

  // R2: hreadyout never goes low without an ERROR showing.
  assert_wait_only_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |-> hresp);

endmodule

// File: rtl/bfr_fault_log.sv
module bfr_fault_log
  import bfr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          log_en,
  input  fault_cls_e    cls_in,
  input  logic [AW-1:0] addr_in,
  input  xfer_attr_t    attr_in,
  input  logic          clear,
  output logic          valid_q,
  output fault_cls_e    cls_q,
  output logic [AW-1:0] addr_q,
  output xfer_attr_t    attr_q,
  output logic          ovf_q
);

  // The record is free to take a new fault when it is empty or being cleared.
  logic room;
  assign room = !valid_q || clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= FC_NONE;
      addr_q  <= '0;
      attr_q  <= '0;
      ovf_q   <= 1'b0;
    end else if (log_en && room) begin
      valid_q <= 1'b1;
      cls_q   <= cls_in;
      addr_q  <= addr_in;
      attr_q  <= attr_in;
      ovf_q   <= 1'b0;
    end else if (log_en) begin
      ovf_q   <= 1'b1;
    end else if (clear) begin
      valid_q <= 1'b0;
      cls_q   <= FC_NONE;
      ovf_q   <= 1'b0;
    end
  end

  // R8: a fault that arrives while the record is full leaves it unchanged and raises overflow.
  assert_keep_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && log_en && !clear) |=> ($stable(addr_q) && $stable(cls_q) && ovf_q));

  // R9: a clear pulse with no new fault empties the record.
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !log_en) |=> (!valid_q && !ovf_q));

  // R9: an empty record always reads class none.
  assert_empty_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (cls_q == FC_NONE));

endmodule

// File: rtl/bus_fault_responder.sv
module bus_fault_responder
  import bfr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] RGN_BASE =
    {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NREG-1:0][AW-1:0] RGN_MASK =
    {32'hF000_0000, 32'hFFFF_0000, 32'hFFFF_F000, 32'hFFFF_0000},
  parameter logic [NREG-1:0]         RGN_SECURE = 4'b0010,
  parameter logic [NREG-1:0][2:0]    RGN_MAXSZ  = {3'd2, 3'd0, 3'd2, 3'd2}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    htrans,
  input  logic [AW-1:0] haddr,
  input  logic [2:0]    hsize,
  input  logic          hwrite,
  input  logic          hnonsec,
  input  logic          hready,
  output logic          hreadyout,
  output logic          hresp,
  input  logic          flt_clear,
  output logic          flt_valid,
  output logic [1:0]    flt_class,
  output logic [AW-1:0] flt_addr,
  output logic [2:0]    flt_size,
  output logic          flt_write,
  output logic          flt_nonsec,
  output logic          flt_overflow
);

  fault_cls_e cls_now;
  fault_cls_e cls_log;
  xfer_attr_t attr_now;
  xfer_attr_t attr_log;
  logic       accept;
  logic       take_err;
  logic       unused_htrans0;

  // htrans[1] alone tells an active transfer (NONSEQ or SEQ) from IDLE or BUSY.
  assign unused_htrans0 = htrans[0];
  assign accept   = hready && htrans[1];
  assign take_err = accept && (cls_now != FC_NONE);
  assign attr_now = '{nonsec: hnonsec, write: hwrite, size: hsize};

  bfr_region_match #(
    .AW(AW), .NREG(NREG),
    .RGN_BASE(RGN_BASE), .RGN_MASK(RGN_MASK),
    .RGN_SECURE(RGN_SECURE), .RGN_MAXSZ(RGN_MAXSZ)
  ) u_match (
    .addr   (haddr),
    .size   (hsize),
    .nonsec (hnonsec),
    .cls    (cls_now)
  );

  bfr_resp_fsm u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_err  (take_err),
    .hreadyout (hreadyout),
    .hresp     (hresp)
  );

  bfr_fault_log #(.AW(AW)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .log_en  (take_err),
    .cls_in  (cls_now),
    .addr_in (haddr),
    .attr_in (attr_now),
    .clear   (flt_clear),
    .valid_q (flt_valid),
    .cls_q   (cls_log),
    .addr_q  (flt_addr),
    .attr_q  (attr_log),
    .ovf_q   (flt_overflow)
  );

  assign flt_class  = cls_log;
  assign flt_size   = attr_log.size;
  assign flt_write  = attr_log.write;
  assign flt_nonsec = attr_log.nonsec;

  // R1: an accepted active transfer that decodes as unmapped opens an ERROR next cycle.
  assert_unmapped_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_now == FC_UNMAPPED) |=> (hresp && !hreadyout));

  // R7: an accepted IDLE or BUSY phase is answered OKAY with no wait.
  assert_idle_okay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !htrans[1]) |=> (!hresp && hreadyout));

  // R7: a legal active transfer leaves the fault record untouched.
  assert_legal_nolog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_now == FC_NONE && !flt_clear) |=> ($stable(flt_valid) && $stable(flt_overflow)));

endmodule

// File: tb/bus_fault_responder_tb.sv
module bus_fault_responder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic [31:0] haddr = '0;
  logic [2:0]  hsize = 3'd0;
  logic        hwrite = 1'b0;
  logic        hnonsec = 1'b0;
  logic        hready;
  logic        hreadyout, hresp;
  logic        flt_clear = 1'b0;
  logic        flt_valid, flt_write, flt_nonsec, flt_overflow;
  logic [1:0]  flt_class;
  logic [31:0] flt_addr;
  logic [2:0]  flt_size;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz
  assign hready = hreadyout;

  bus_fault_responder u_dut (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .haddr(haddr), .hsize(hsize),
    .hwrite(hwrite), .hnonsec(hnonsec), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .flt_clear(flt_clear),
    .flt_valid(flt_valid), .flt_class(flt_class), .flt_addr(flt_addr),
    .flt_size(flt_size), .flt_write(flt_write), .flt_nonsec(flt_nonsec),
    .flt_overflow(flt_overflow)
  );

  typedef struct { bit err; string tag; } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: follows the data phase of each accepted transfer and pops one expectation.
  bit dp = 0;
  bit stage = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit done;
      done = 0;
      if (dp) begin
        if (q.size() == 0) begin
          check(0, "R2 unexpected data phase", 0, 1);
          done = 1;
        end else if (q[0].err) begin
          if (!stage) begin
            check(hresp && !hreadyout, {q[0].tag, " err cycle1"}, {hresp, hreadyout}, 2'b10);
            stage = 1;
          end else begin
            check(hresp && hreadyout, {q[0].tag, " err cycle2"}, {hresp, hreadyout}, 2'b11);
            stage = 0;
            done = 1;
          end
        end else begin
          check(!hresp && hreadyout, {q[0].tag, " okay"}, {hresp, hreadyout}, 2'b01);
          done = 1;
        end
        if (done && q.size() != 0) void'(q.pop_front());
      end
      if (htrans[1] && hready) dp = 1;
      else if (done) dp = 0;
    end
  end

  // Driver: drive an active transfer and hold it until accepted.
  task automatic issue(input logic [31:0] a, input logic [2:0] sz, input bit wr,
                       input bit ns, input bit exp_err, input string tag, input bit seq = 0);
    bit ok;
    exp_t e;
    e.err = exp_err; e.tag = tag;
    q.push_back(e);
    htrans = seq ? 2'b11 : 2'b10; haddr = a; hsize = sz; hwrite = wr; hnonsec = ns;
    do begin
      @(negedge clk); ok = hready;
      @(posedge clk);
    end while (!ok);
    #1;
  endtask

  task automatic idle(input int n, input logic [1:0] tr = 2'b00, input logic [31:0] a = 32'h0);
    htrans = tr; haddr = a;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    flt_clear = 1'b1;
    @(posedge clk); #1;
    flt_clear = 1'b0;
  endtask

  task automatic check_log(input bit v, input logic [1:0] c, input bit ov, input string tag);
    check(flt_valid == v, {tag, " valid"}, flt_valid, v);
    check(flt_class == c, {tag, " class"}, flt_class, c);
    check(flt_overflow == ov, {tag, " overflow"}, flt_overflow, ov);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: reset state
    check(hreadyout == 1 && hresp == 0, "R10 bus outputs", {hreadyout, hresp}, 2'b10);
    check_log(0, 2'b00, 0, "R10");

    // R7: legal word read to region 0
    issue(32'h0000_1234, 3'd2, 0, 1, 0, "R7 legal");
    idle(3);
    check_log(0, 2'b00, 0, "R7 legal nolog");

    // R7: IDLE and BUSY to unmapped space
    idle(3, 2'b00, 32'h5000_0000);
    idle(3, 2'b01, 32'h5000_0004);
    check(!hresp && hreadyout, "R7 idle/busy okay", {hresp, hreadyout}, 2'b01);
    check_log(0, 2'b00, 0, "R7 idle/busy nolog");

    // R1 and R6: unmapped write, then a legal transfer right behind it
    issue(32'h5000_0040, 3'd1, 1, 1, 1, "R1 unmapped");
    issue(32'h0000_0008, 3'd2, 0, 0, 0, "R6 follower");
    idle(3);
    check_log(1, 2'b01, 0, "R1");
    check(flt_addr == 32'h5000_0040, "R6 addr", flt_addr, 32'h5000_0040);
    check(flt_size == 3'd1 && flt_write && flt_nonsec, "R6 attrs",
          {flt_size, flt_write, flt_nonsec}, {3'd1, 1'b1, 1'b1});

    // R8: second fault while full
    issue(32'h1000_0004, 3'd2, 0, 1, 1, "R8 second");
    idle(3);
    check_log(1, 2'b01, 1, "R8");
    check(flt_addr == 32'h5000_0040, "R8 kept addr", flt_addr, 32'h5000_0040);

    // R9: clear
    pulse_clear();
    check_log(0, 2'b00, 0, "R9 clear");

    // R3: security
    issue(32'h1000_0004, 3'd2, 0, 1, 1, "R3 nonsec");
    idle(3);
    check_log(1, 2'b10, 0, "R3");
    pulse_clear();
    issue(32'h1000_0008, 3'd2, 1, 0, 0, "R3 secure ok");
    idle(3);
    check_log(0, 2'b00, 0, "R3 secure nolog");

    // R4 and R5: region 2 (byte only) wins over region 3
    issue(32'h2000_0010, 3'd1, 0, 0, 1, "R5 halfword");
    idle(3);
    check_log(1, 2'b11, 0, "R4 size");
    pulse_clear();
    issue(32'h2000_0010, 3'd0, 0, 0, 0, "R5 byte ok");
    issue(32'h2100_0000, 3'd2, 1, 0, 0, "R5 region3 word");
    idle(3);
    check_log(0, 2'b00, 0, "R5 nolog");

    // R4: security takes precedence over size
    issue(32'h1000_0000, 3'd3, 0, 1, 1, "R4 both");
    idle(3);
    check_log(1, 2'b10, 0, "R4 precedence");
    pulse_clear();

    // R1: SEQ type to unmapped space
    issue(32'h7000_0000, 3'd2, 0, 0, 1, "R1 seq", 1);
    idle(3);
    check_log(1, 2'b01, 0, "R1 seq");

    // R9: clear in the same cycle as a new fault
    flt_clear = 1'b1;
    issue(32'h1000_0010, 3'd0, 1, 1, 1, "R9 clear+fault");
    flt_clear = 1'b0;
    idle(3);
    check_log(1, 2'b10, 0, "R9 clear+fault");
    check(flt_addr == 32'h1000_0010, "R9 new addr", flt_addr, 32'h1000_0010);

    // R2 and R8: two faults back to back
    pulse_clear();
    issue(32'h6000_0000, 3'd2, 0, 0, 1, "R2 b2b first");
    issue(32'h2000_0000, 3'd2, 1, 0, 1, "R2 b2b second");
    idle(4);
    check_log(1, 2'b01, 1, "R8 b2b");
    check(flt_addr == 32'h6000_0000, "R8 b2b addr", flt_addr, 32'h6000_0000);
    check(q.size() == 0, "R2 all responses seen", q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule